// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block keeps wall-clock time in binary-coded decimal: a tenths-of-a-second digit, two-digit seconds and minutes, and a 12-hour hour count with an AM/PM flag. It is advanced by a slow, asynchronous tick derived from the mains frequency. The tick is synchronised and edge-detected, then divided by 5 or 6 so that a 50 Hz or 60 Hz source gives ten updates per second. A second register set holds an alarm time. Each time the tenths update, the new time is compared with the alarm. A match produces a single-cycle pulse for a neighbouring interrupt controller.

Software reaches the block through a byte-wide port with four addresses. A mode input steers writes either to the alarm set or to the running time. Reads always return the running time. Reading the hour field takes a snapshot of all four fields, and the reads that follow return that snapshot until the tenths field is read. A multi-byte read started at the hours therefore cannot tear across a carry, and the clock keeps counting meanwhile.

Top module: `tod_clock`

## Requirements
- R1: After reset every time and alarm field reads 0, `alarm_pulse` is low, the readout is not frozen and the prescaler is 0, so the first qualified tick already advances the tenths.
- R2: Each rising edge of `tick_in` counts once, however long the input stays high. With `rate_sel`=1 the tenths advance on the 1st, 6th, 11th... edge (every 5th edge); with `rate_sel`=0 they advance on every 6th edge.
- R3: Tenths count 0 to 9 and carry into the seconds. Seconds and minutes count in BCD from 0x00 to 0x59, and each wrap carries upward.
- R4: The hour byte holds BCD hours 00 to 11 in bits 4:0 and the PM flag in bit 7, with bits 6:5 reading 0. Advancing from hour 0x11 gives hour 0x00 with bit 7 inverted; 0x09 advances to 0x10.
- R5: The address map is 0 = tenths, 1 = seconds, 2 = minutes, 3 = hours. Written bytes are masked with 0x0F, 0x7F, 0x7F and 0x9F respectively.
- R6: A write with `alarm_mode`=1 updates only the alarm field and leaves the running time unchanged. A write with `alarm_mode`=0 updates only the time field. Reads return time fields in both modes.
- R7: A read (`rd_en`) of address 3 returns the live hour byte and freezes all four readout fields. While frozen the clock keeps advancing. A read of address 0 returns the frozen tenths and unfreezes, after which reads show live time.
- R8: `alarm_pulse` is high for exactly one cycle, in the cycle after a tenths update whose resulting time equals all four alarm fields. It is low at all other times.
- R9: When a time write lands in the same cycle as a tenths update, the written field takes the written value and the other fields advance normally. Writes never disturb the prescaler.
- R10: Reading address 3 again while the readout is frozen does not refresh the snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Asynchronous mains-rate tick |
| rate_sel | input | 1 | 1: divide ticks by 5, 0: divide by 6 |
| alarm_mode | input | 1 | 1: writes go to alarm fields, 0: to time fields |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the freeze/unfreeze side effects) |
| addr | input | 2 | Field select (0 tenths, 1 seconds, 2 minutes, 3 hours) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Selected time field, live or frozen |
| alarm_pulse | output | 1 | One-cycle alarm match pulse |

## Verification
On every cycle the assertions check the following: the edge detector yields single-cycle rises, and the prescaler holds between rises and reloads after an update. They check that the tenths, seconds, minutes and hours wrap with the right carries, and that the time stays put when neither an update nor a write occurs. They also check that a frozen snapshot stays stable and that every alarm pulse follows an update on a matching time. The bench's scenarios are needed for the exact tick-to-update ratio under both rates, the write masks and the routing by mode, and the first-tick advance after reset. The scenarios also show the unfreeze on a tenths read, a second hour read that leaves the snapshot untouched, and writes that collide with an update.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    F_TENTHS = 2'd0,
    F_SEC    = 2'd1,
    F_MIN    = 2'd2,
    F_HOUR   = 2'd3
  } tod_field_e;

  typedef struct packed {
    logic       pm;
    logic [4:0] hr;
    logic [6:0] mn;
    logic [6:0] sc;
    logic [3:0] tn;
  } tod_time_t;

  // {carry, next tenths}
  function automatic logic [4:0] tenth_step(logic [3:0] v);
    logic [4:0] s;
    s = {1'b0, v} + 5'd1;
    if (s > 5'd9) return 5'b1_0000;
    return s;
  endfunction

  // {carry, next value} for a 00..59 BCD field
  function automatic logic [7:0] sexa_step(logic [6:0] v);
    logic [4:0] lo;
    logic [3:0] hi;
    lo = {1'b0, v[3:0]} + 5'd1;
    hi = {1'b0, v[6:4]};
    if (lo > 5'd9) begin
      lo = 5'd0;
      hi = hi + 4'd1;
    end
    if (hi > 4'd5) return 8'h80;
    return {1'b0, hi[2:0], lo[3:0]};
  endfunction

  // {pm, hour} after one hour step, 12-hour wrap at 0x11
  function automatic logic [5:0] hour_step(logic pm, logic [4:0] h);
    logic [4:0] lo;
    logic [1:0] hi;
    logic [5:0] f;
    lo = {1'b0, h[3:0]} + 5'd1;
    hi = {1'b0, h[4]};
    if (lo > 5'd9) begin
      lo = 5'd0;
      hi = hi + 2'd1;
    end
    f = {hi, lo[3:0]};
    if (f > 6'h11) return {~pm, 5'd0};
    return {pm, f[4:0]};
  endfunction

  function automatic tod_time_t tod_advance(tod_time_t t);
    tod_time_t  r;
    logic [4:0] ts;
    logic [7:0] ss;
    logic [7:0] ms;
    logic [5:0] hs;
    r  = t;
    ts = tenth_step(t.tn);
    r.tn = ts[3:0];
    if (ts[4]) begin
      ss = sexa_step(t.sc);
      r.sc = ss[6:0];
      if (ss[7]) begin
        ms = sexa_step(t.mn);
        r.mn = ms[6:0];
        if (ms[7]) begin
          hs = hour_step(t.pm, t.hr);
          r.pm = hs[5];
          r.hr = hs[4:0];
        end
      end
    end
    return r;
  endfunction

  function automatic tod_time_t tod_apply_write(tod_time_t t, tod_field_e f,
                                                logic [BYTE_W-1:0] d);
    tod_time_t r;
    r = t;
    case (f)
      F_TENTHS: r.tn = d[3:0];
      F_SEC:    r.sc = d[6:0];
      F_MIN:    r.mn = d[6:0];
      default: begin
        r.hr = d[4:0];
        r.pm = d[7];
      end
    endcase
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] tod_field_byte(tod_time_t t, tod_field_e f);
    case (f)
      F_TENTHS: return {4'd0, t.tn};
      F_SEC:    return {1'b0, t.sc};
      F_MIN:    return {1'b0, t.mn};
      default:  return {t.pm, 2'b00, t.hr};
    endcase
  endfunction

endpackage

// File: rtl/tod_tick_prescaler.sv
`timescale 1ns/1ps
module tod_tick_prescaler #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_FAST    = 5,
  parameter int DIV_SLOW    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic rate_sel,
  output logic tick_rise,
  output logic tenth_adv
);
  localparam int DIV_MAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CNT_W-1:0]       pre_q;
  logic [CNT_W-1:0]       reload;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= tick_in;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], tick_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign tick_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign reload    = rate_sel ? CNT_W'(DIV_FAST - 1) : CNT_W'(DIV_SLOW - 1);
  assign tenth_adv = tick_rise && (pre_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_q <= '0;
    else if (tick_rise) begin
      if (pre_q == '0)       pre_q <= reload;
      else                   pre_q <= pre_q - 1'b1;
    end
  end

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |=> !tick_rise);

  // R2
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_rise |=> $stable(pre_q));

  // R2
  pre_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tenth_adv |=> (pre_q == $past(reload)));

endmodule

// File: rtl/tod_time_counter.sv
`timescale 1ns/1ps
module tod_time_counter
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tenth_adv,
  input  logic              wr_time,
  input  tod_field_e        wr_field,
  input  logic [BYTE_W-1:0] wr_data,
  output tod_time_t         time_q,
  output tod_time_t         time_nx
);
  tod_time_t stepped;

  // named carry events for the checks below
  logic tn_wrap, sc_wrap, mn_wrap, hr_wrap;
  assign tn_wrap = tenth_adv && !wr_time && (time_q.tn == 4'd9);
  assign sc_wrap = tn_wrap && (time_q.sc == 7'h59);
  assign mn_wrap = sc_wrap && (time_q.mn == 7'h59);
  assign hr_wrap = mn_wrap && (time_q.hr == 5'h11);

  always_comb begin
    stepped = tenth_adv ? tod_advance(time_q) : time_q;
    time_nx = wr_time ? tod_apply_write(stepped, wr_field, wr_data) : stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_nx;
  end

  // R3
  tenth_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tn_wrap |=> (time_q.tn == 4'd0));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wrap |=> (time_q.sc == 7'h00));

  // R3
  min_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mn_wrap |=> (time_q.mn == 7'h00));

  // R4
  hour_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hr_wrap |=> ((time_q.hr == 5'h00) && (time_q.pm != $past(time_q.pm))));

  // R6
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tenth_adv && !wr_time) |=> $stable(time_q));

endmodule

// File: rtl/tod_alarm_unit.sv
`timescale 1ns/1ps
module tod_alarm_unit
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_alarm,
  input  tod_field_e        wr_field,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              upd,
  input  tod_time_t         time_nx,
  input  tod_time_t         time_q,
  output logic              alarm_pulse
);
  tod_time_t alarm_q;
  logic      hit;

  assign hit = upd && (time_nx == alarm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q     <= '0;
      alarm_pulse <= 1'b0;
    end else begin
      alarm_pulse <= hit;
      if (wr_alarm) alarm_q <= tod_apply_write(alarm_q, wr_field, wr_data);
    end
  end

  // R8
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(upd));

  // R8
  pulse_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_pulse && !$past(wr_alarm)) |-> (time_q == alarm_q));

endmodule

// File: rtl/tod_readout.sv
`timescale 1ns/1ps
module tod_readout
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  tod_field_e        rd_field,
  input  tod_time_t         time_q,
  output logic [BYTE_W-1:0] rdata
);
  tod_time_t snap_q;
  logic      frozen_q;
  logic      freeze_req, thaw_req;

  assign freeze_req = rd_en && (rd_field == F_HOUR) && !frozen_q;
  assign thaw_req   = rd_en && (rd_field == F_TENTHS) && frozen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen_q <= 1'b0;
      snap_q   <= '0;
    end else if (freeze_req) begin
      frozen_q <= 1'b1;
      snap_q   <= time_q;
    end else if (thaw_req) begin
      frozen_q <= 1'b0;
    end
  end

  assign rdata = tod_field_byte(frozen_q ? snap_q : time_q, rd_field);

  // R7
  freeze_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_req |=> (frozen_q && (snap_q == $past(time_q))));

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !thaw_req) |=> (frozen_q && $stable(snap_q)));

  // R7
  thaw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thaw_req |=> !frozen_q);

endmodule

// File: rtl/tod_clock.sv
`timescale 1ns/1ps
module tod_clock
  import tod_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_FAST    = 5,
  parameter int DIV_SLOW    = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  input  logic       rate_sel,
  input  logic       alarm_mode,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       alarm_pulse
);
  logic       tick_rise;
  logic       tenth_adv;
  logic       wr_time, wr_alarm;
  tod_field_e field;
  tod_time_t  time_q, time_nx;

  assign field    = tod_field_e'(addr);
  assign wr_time  = wr_en && !alarm_mode;
  assign wr_alarm = wr_en && alarm_mode;

  tod_tick_prescaler #(
    .SYNC_STAGES (SYNC_STAGES),
    .DIV_FAST    (DIV_FAST),
    .DIV_SLOW    (DIV_SLOW)
  ) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_in   (tick_in),
    .rate_sel  (rate_sel),
    .tick_rise (tick_rise),
    .tenth_adv (tenth_adv)
  );

  tod_time_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tenth_adv (tenth_adv),
    .wr_time   (wr_time),
    .wr_field  (field),
    .wr_data   (wdata),
    .time_q    (time_q),
    .time_nx   (time_nx)
  );

  tod_alarm_unit u_alm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_alarm    (wr_alarm),
    .wr_field    (field),
    .wr_data     (wdata),
    .upd         (tenth_adv),
    .time_nx     (time_nx),
    .time_q      (time_q),
    .alarm_pulse (alarm_pulse)
  );

  tod_readout u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_field (field),
    .time_q   (time_q),
    .rdata    (rdata)
  );

  // R2
  adv_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tenth_adv |-> tick_rise);

endmodule

// File: tb/sim_tod_clock.sv
`timescale 1ns/1ps
module sim_tod_clock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0;
  logic       rate_sel = 1'b1;
  logic       alarm_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       alarm_pulse;

  always #2 clk = ~clk;

  tod_clock u0 (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .rate_sel(rate_sel),
    .alarm_mode(alarm_mode), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .alarm_pulse(alarm_pulse)
  );

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";
  bit finished = 0;

  // reference model state (raw register bytes)
  int m_tn, m_sc, m_mn, m_hr, m_pm;
  int a_by[4];
  int snap[4];
  bit frozen;
  int pre;
  bit exp_pulse;
  int pulses_seen;
  bit hist[$];

  function automatic int b2d(int b); return (b >> 4) * 10 + (b & 15); endfunction
  function automatic int d2b(int d); return ((d / 10) << 4) | (d % 10); endfunction

  function automatic int live(int f);
    case (f)
      0: return m_tn;
      1: return m_sc;
      2: return m_mn;
      default: return (m_pm << 7) | m_hr;
    endcase
  endfunction

  task automatic model_reset();
    m_tn = 0; m_sc = 0; m_mn = 0; m_hr = 0; m_pm = 0;
    foreach (a_by[i]) a_by[i] = 0;
    foreach (snap[i]) snap[i] = 0;
    frozen = 0; pre = 0; exp_pulse = 0;
    hist = '{0, 0, 0};
  endtask

  task automatic model_advance();
    int v;
    if (m_tn >= 9) begin
      m_tn = 0;
      v = b2d(m_sc) + 1;
      if (v >= 60) begin
        m_sc = 0;
        v = b2d(m_mn) + 1;
        if (v >= 60) begin
          m_mn = 0;
          v = b2d(m_hr) + 1;
          if (v >= 12) begin m_hr = 0; m_pm = m_pm ^ 1; end
          else m_hr = d2b(v);
        end else m_mn = d2b(v);
      end else m_sc = d2b(v);
    end else m_tn = m_tn + 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit rise, adv;
      rise = hist[1] && !hist[2];
      adv  = rise && (pre == 0);
      if (rise) pre = (pre == 0) ? (rate_sel ? 4 : 5) : pre - 1;
      if (rd_en && addr == 3 && !frozen) begin
        frozen = 1;
        for (int i = 0; i < 4; i++) snap[i] = live(i);
      end else if (rd_en && addr == 0 && frozen) frozen = 0;
      if (adv) model_advance();
      if (wr_en && !alarm_mode) begin
        case (addr)
          2'd0: m_tn = wdata & 8'h0F;
          2'd1: m_sc = wdata & 8'h7F;
          2'd2: m_mn = wdata & 8'h7F;
          default: begin m_hr = wdata & 8'h1F; m_pm = wdata[7]; end
        endcase
      end
      exp_pulse = adv && (live(0) == a_by[0]) && (live(1) == a_by[1]) &&
                  (live(2) == a_by[2]) && (live(3) == a_by[3]);
      if (wr_en && alarm_mode)
        a_by[addr] = wdata & ((addr == 0) ? 8'h0F : (addr == 3) ? 8'h9F : 8'h7F);
      hist.push_front(tick_in);
      void'(hist.pop_back());
    end
  end

  task automatic step();
    int exp_rd;
    #1;
    exp_rd = frozen ? snap[addr] : live(addr);
    vectors++;
    if (rdata !== 8'(exp_rd) || alarm_pulse !== exp_pulse) begin
      miscompares++;
      $display("FAIL %s: addr=%0d rdata=%02h pulse=%b expected rdata=%02h pulse=%b",
               cur_req, addr, rdata, alarm_pulse, 8'(exp_rd), exp_pulse);
    end
    if (alarm_pulse === 1'b1) pulses_seen++;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
    rd_en = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      addr = addr + 2'd1;
      step();
    end
  endtask

  task automatic tick(int hi, int lo);
    tick_in = 1; idle(hi);
    tick_in = 0; idle(lo);
  endtask

  task automatic wr(bit mode, int a, int d);
    alarm_mode = mode; wr_en = 1; addr = 2'(a); wdata = 8'(d);
    step();
    alarm_mode = 0;
  endtask

  task automatic rd(int a);
    rd_en = 1; addr = 2'(a);
    step();
  endtask

  task automatic set_time(int h, int m, int s, int t);
    wr(0, 3, h); wr(0, 2, m); wr(0, 1, s); wr(0, 0, t);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state on all four fields, first tick advances at once
    cur_req = "R1";
    idle(4);
    tick(3, 3);
    idle(4);

    // R2: both divide ratios and a long-held tick
    cur_req = "R2";
    rate_sel = 1;
    for (int i = 0; i < 12; i++) tick(2, 2);
    rate_sel = 0;
    for (int i = 0; i < 14; i++) tick(2, 3);
    tick(20, 3);
    rate_sel = 1;

    // R3: seconds and minutes carries
    cur_req = "R3";
    set_time(8'h02, 8'h59, 8'h59, 8);
    for (int i = 0; i < 12; i++) tick(2, 2);
    idle(4);

    // R4: hour carries and 12-hour wrap with PM toggle
    cur_req = "R4";
    set_time(8'h09, 8'h59, 8'h59, 9);
    for (int i = 0; i < 6; i++) tick(2, 2);
    set_time(8'h11, 8'h59, 8'h59, 9);
    for (int i = 0; i < 6; i++) tick(2, 2);
    set_time(8'h91, 8'h59, 8'h59, 9);
    for (int i = 0; i < 6; i++) tick(2, 2);
    idle(4);

    // R5: write masks per address
    cur_req = "R5";
    wr(0, 0, 8'hFF); idle(4);
    wr(0, 1, 8'hFF); idle(4);
    wr(0, 2, 8'hFF); idle(4);
    wr(0, 3, 8'hFF); idle(4);
    set_time(8'h04, 8'h20, 8'h30, 0);
    idle(4);

    // R6: alarm-mode writes leave time unchanged
    cur_req = "R6";
    wr(1, 0, 8'h07); wr(1, 1, 8'h11); wr(1, 2, 8'h22); wr(1, 3, 8'h85);
    idle(8);

    // R8: alarm match pulse exactly once
    cur_req = "R8";
    set_time(8'h03, 8'h15, 8'h42, 5);
    wr(1, 3, 8'h03); wr(1, 2, 8'h15); wr(1, 1, 8'h42); wr(1, 0, 8'h06);
    pulses_seen = 0;
    for (int i = 0; i < 6; i++) tick(2, 2);
    idle(4);
    vectors++;
    if (pulses_seen != 1) begin
      miscompares++;
      $display("FAIL R8: pulses=%0d expected 1", pulses_seen);
    end

    // R7: freeze on hour read, clock runs, thaw on tenths read
    cur_req = "R7";
    set_time(8'h05, 8'h10, 8'h20, 3);
    rd(3);
    for (int i = 0; i < 8; i++) tick(2, 2);
    idle(4);
    // R10: second hour read keeps the old snapshot
    cur_req = "R10";
    rd(3);
    for (int i = 0; i < 6; i++) tick(2, 2);
    idle(4);
    cur_req = "R7";
    rd(0);
    idle(4);

    // R9: writes around and on an update cycle
    cur_req = "R9";
    for (int k = 0; k < 6; k++) begin
      tick_in = 1;
      for (int j = 0; j < 4; j++) wr(0, 1, 8'h10 + k);
      tick_in = 0;
      idle(3);
    end
    idle(4);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: state=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule